// File: doc/BRIEF.md
# Parallel Fixed-Point Neuron

This block computes one artificial neuron in two's-complement fixed point. Each enabled beat presents `N_IN` signed inputs and `N_IN` signed weights. The block forms every product in parallel and reduces the products through a registered adder tree, which is pipelined by level. The tree result is then accumulated into a wide sum register. A beat that carries the clear flag restarts that register from the aligned bias. Later beats that do not carry the flag add onto it. This lets a long dot product be fed in slices of `N_IN` terms.

After every accumulation the running sum is rounded and saturated back to a 10-bit word. It then passes through the activation chosen for that beat, either ReLU or a sigmoid read from a 64-entry lookup table. The result appears with a one-cycle valid strobe after a fixed pipeline latency. Back-to-back beats are accepted. The clear flag and the activation choice travel down the pipeline with their own beat.

Data words are 10 bits with `FRAC = 6` fraction bits, so 64 represents 1.0. Products carry 12 fraction bits until the output stage.

Top module: `nrn_fx_neuron`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first result, `valid_o` is 0 and `y_o` is 0.
- R2: A beat sampled with `enable_i` high at a rising edge raises `valid_o` for one cycle exactly `$clog2(N_IN)+3` rising edges later, counting the sampling edge as the first. With the defaults this is 5 edges.
- R3: A beat with `enable_i` and `clear_i` both high sets the sum to `bias_i*64` plus the sum of `x*w` over all lanes. Lane i occupies bits `[i*10 +: 10]` of `x_i` and `w_i`. `clear_i` has no effect while `enable_i` is low.
- R4: A beat with `enable_i` high and `clear_i` low adds the sum of its lane products to the current sum.
- R5: The sum, scaled by 4096 = 1.0, is converted to the output scale as floor((sum + 32) / 64). A value exactly halfway between two steps rounds up.
- R6: The converted value saturates to the range [-512, 511].
- R7: With `act_sel_i` = 0 (ReLU), `y_o` is the saturated value when it is non-negative and 0 when it is negative.
- R8: With `act_sel_i` = 1 (sigmoid), let k = floor(v/8), where v is the saturated value, clamped to [-32, 31], and let a = |k|. Then h = 54 + floor(a/4) for a >= 19, h = 40 + a for 8 <= a < 19, and h = 32 + 2a for a < 8. `y_o` is h when k >= 0 and 64 - h when k < 0.
- R9: The activation choice and the clear flag apply to the beat they were sampled with, also when beats arrive on consecutive cycles with differing choices.
- R10: While no result is being delivered, `y_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Beat valid |
| clear_i | input | 1 | Restart the sum from the bias on this beat |
| act_sel_i | input | 1 | 0 = ReLU, 1 = sigmoid |
| x_i | input | N_IN*DW | Packed signed inputs |
| w_i | input | N_IN*DW | Packed signed weights |
| bias_i | input | DW | Signed bias |
| y_o | output | DW | Activated output |
| valid_o | output | 1 | Result strobe |

## Verification
The bench targets the exact half-step on rounding. A design that truncates instead of rounding returns 0 where 1 is expected. Products large enough to exceed the 10-bit range check saturation: a design without it wraps them to a negative value, which ReLU then turns into 0. Both sigmoid table clamps are driven, along with the centre entry, so an off-by-one index or a missing clamp shows up as a wrong code. Consecutive beats with alternating activation and clear flags catch sideband that slips a pipeline stage against its data. A clear raised while no beat is enabled must leave the running sum untouched for the next beat to add onto.

// File: rtl/nrn_pkg.sv
package nrn_pkg;
  typedef enum logic {ACT_RELU = 1'b0, ACT_SIGM = 1'b1} act_e;

  // sigmoid code at 1/8 steps, output scale 64 = 1.0
  function automatic int sig_code(int k);
    int a, h;
    a = (k < 0) ? -k : k;
    if (a >= 19)     h = 54 + a / 4;
    else if (a >= 8) h = 40 + a;
    else             h = 32 + 2 * a;
    return (k < 0) ? 64 - h : h;
  endfunction
endpackage

// File: rtl/nrn_mul_bank.sv
module nrn_mul_bank #(
  parameter int N_IN   = 4,
  parameter int DW     = 10,
  parameter int SIDE_W = 12,
  localparam int PW    = 2 * DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic [SIDE_W-1:0]    side_i,
  input  logic [N_IN*DW-1:0]   x_i,
  input  logic [N_IN*DW-1:0]   w_i,
  output logic                 vld_o,
  output logic [SIDE_W-1:0]    side_o,
  output logic [N_IN*PW-1:0]   prod_o
);
  for (genvar i = 0; i < N_IN; i++) begin : gen_lane
    logic signed [PW-1:0] p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    p_q <= '0;
      else if (vld_i) p_q <= $signed(x_i[i*DW +: DW]) * $signed(w_i[i*DW +: DW]);
    end
    assign prod_o[i*PW +: PW] = p_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      side_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) side_o <= side_i;
    end
  end
endmodule

// File: rtl/nrn_add_tree.sv
module nrn_add_tree #(
  parameter int N_IN   = 4,
  parameter int PW     = 20,
  parameter int SIDE_W = 12,
  localparam int LVLS  = $clog2(N_IN),
  localparam int NP    = 1 << LVLS,
  localparam int SW    = PW + LVLS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic [SIDE_W-1:0]     side_i,
  input  logic [N_IN*PW-1:0]    prod_i,
  output logic                  vld_o,
  output logic [SIDE_W-1:0]     side_o,
  output logic signed [SW-1:0]  sum_o
);
  logic              vld_q  [LVLS+1];
  logic [SIDE_W-1:0] side_q [LVLS+1];

  assign vld_q[0]  = vld_i;
  assign side_q[0] = side_i;

  for (genvar l = 0; l <= LVLS; l++) begin : gen_lvl
    localparam int CNT = NP >> l;
    logic signed [SW-1:0] s [CNT];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : gen_j
        if (j < N_IN) begin : g_used
          assign s[j] = SW'($signed(prod_i[j*PW +: PW]));
        end else begin : g_pad
          assign s[j] = '0;
        end
      end
    end else begin : g_node
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int j = 0; j < CNT; j++) s[j] <= '0;
        end else if (vld_q[l-1]) begin
          for (int j = 0; j < CNT; j++) s[j] <= gen_lvl[l-1].s[2*j] + gen_lvl[l-1].s[2*j+1];
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[l]  <= 1'b0;
          side_q[l] <= '0;
        end else begin
          vld_q[l] <= vld_q[l-1];
          if (vld_q[l-1]) side_q[l] <= side_q[l-1];
        end
      end
    end
  end

  assign sum_o  = gen_lvl[LVLS].s[0];
  assign vld_o  = vld_q[LVLS];
  assign side_o = side_q[LVLS];

  p_tree_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(vld_i, LVLS));
endmodule

// File: rtl/nrn_act.sv
module nrn_act
  import nrn_pkg::*;
#(
  parameter int DW    = 10,
  parameter int FRAC  = 6,
  parameter int ACC_W = 26
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  act_e                    sel_i,
  output logic [DW-1:0]           y_o
);
  localparam int TAB_N = 64;
  localparam int HALF  = TAB_N / 2;
  localparam int SH    = FRAC - 3;
  localparam int MAX_V = 2 ** (DW - 1) - 1;
  localparam int MIN_V = -(2 ** (DW - 1));

  logic signed [ACC_W:0] rnd, q;
  logic signed [DW-1:0]  sat, k;
  logic [5:0]            idx;
  logic [DW-1:0]         lut [TAB_N];

  for (genvar i = 0; i < TAB_N; i++) begin : gen_lut
    assign lut[i] = DW'(sig_code(i - HALF));
  end

  always_comb begin
    rnd = {acc_i[ACC_W-1], acc_i} + (ACC_W+1)'(2 ** (FRAC - 1));
    q   = rnd >>> FRAC;
    if (q > $signed((ACC_W+1)'(MAX_V)))      sat = DW'(MAX_V);
    else if (q < $signed((ACC_W+1)'(MIN_V))) sat = DW'(MIN_V);
    else                                     sat = q[DW-1:0];
    k = sat >>> SH;
    if (k > $signed(DW'(HALF - 1)))    idx = 6'(TAB_N - 1);
    else if (k < $signed(DW'(-HALF)))  idx = 6'd0;
    else                               idx = 6'(k + DW'(HALF));
    if (sel_i == ACT_SIGM) y_o = lut[idx];
    else                   y_o = sat[DW-1] ? '0 : sat;
  end
endmodule

// File: rtl/nrn_fx_neuron.sv
module nrn_fx_neuron
  import nrn_pkg::*;
#(
  parameter int N_IN      = 4,
  parameter int DW        = 10,
  parameter int FRAC      = 6,
  parameter int ACC_GUARD = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               clear_i,
  input  logic               act_sel_i,
  input  logic [N_IN*DW-1:0] x_i,
  input  logic [N_IN*DW-1:0] w_i,
  input  logic [DW-1:0]      bias_i,
  output logic [DW-1:0]      y_o,
  output logic               valid_o
);
  localparam int LVLS   = $clog2(N_IN);
  localparam int PW     = 2 * DW;
  localparam int SW     = PW + LVLS;
  localparam int ACC_W  = SW + ACC_GUARD;
  localparam int SIDE_W = DW + 2;
  localparam int LAT    = LVLS + 3;

  logic                  m_vld, t_vld, acc_vld_q;
  logic [SIDE_W-1:0]     m_side, t_side;
  logic [N_IN*PW-1:0]    prod;
  logic signed [SW-1:0]  t_sum;
  logic signed [ACC_W-1:0] acc_q, bias_al, base;
  act_e                  act_q;
  logic [DW-1:0]         y_act;

  nrn_mul_bank #(.N_IN(N_IN), .DW(DW), .SIDE_W(SIDE_W)) u_mul (
    .clk_i, .rst_ni,
    .vld_i (enable_i),
    .side_i({clear_i, act_sel_i, bias_i}),
    .x_i, .w_i,
    .vld_o (m_vld),
    .side_o(m_side),
    .prod_o(prod)
  );

  nrn_add_tree #(.N_IN(N_IN), .PW(PW), .SIDE_W(SIDE_W)) u_tree (
    .clk_i, .rst_ni,
    .vld_i (m_vld),
    .side_i(m_side),
    .prod_i(prod),
    .vld_o (t_vld),
    .side_o(t_side),
    .sum_o (t_sum)
  );

  // side = {clear, act, bias}
  always_comb begin
    bias_al = $signed({{(ACC_W-DW){t_side[DW-1]}}, t_side[DW-1:0]}) <<< FRAC;
    base    = t_side[DW+1] ? bias_al : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      acc_vld_q <= 1'b0;
      act_q     <= ACT_RELU;
    end else begin
      acc_vld_q <= t_vld;
      if (t_vld) begin
        acc_q <= base + ACC_W'(t_sum);
        act_q <= act_e'(t_side[DW]);
      end
    end
  end

  nrn_act #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W)) u_act (
    .acc_i(acc_q),
    .sel_i(act_q),
    .y_o  (y_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= acc_vld_q;
      if (acc_vld_q) y_o <= y_act;
    end
  end

  p_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(enable_i, LAT));
  p_relu_nonneg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(act_q) == ACT_RELU) |-> !y_o[DW-1]);
  p_sig_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(act_q) == ACT_SIGM) |-> (y_o > DW'(0) && y_o < DW'(64)));
  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_o));
endmodule

// File: tb/nrn_fx_neuron_bench.sv
module nrn_fx_neuron_bench;
  localparam int N = 4;
  localparam int DW = 10;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, clear_i = 1'b0, act_sel_i = 1'b0;
  logic [N*DW-1:0] x_i = '0, w_i = '0;
  logic [DW-1:0] bias_i = '0;
  logic [DW-1:0] y_o;
  logic valid_o;

  always #4 clk = ~clk;

  nrn_fx_neuron u_nrn_fx_neuron (
    .clk_i(clk), .rst_ni, .enable_i, .clear_i, .act_sel_i,
    .x_i, .w_i, .bias_i, .y_o, .valid_o
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  longint acc_m = 0;
  int last_exp = 0;
  int q_val[$];
  int q_cyc[$];
  string q_tag[$];

  function automatic int sig_ref(int k);
    int a, h;
    a = k < 0 ? -k : k;
    h = (a >= 19) ? 54 + a / 4 : (a >= 8) ? 40 + a : 32 + 2 * a;
    return k < 0 ? 64 - h : h;
  endfunction

  function automatic int model_out(longint acc, bit sel);
    longint r, q;
    int v, k;
    r = acc + 32;
    q = (r >= 0) ? r / 64 : -((-r + 63) / 64);
    v = (q > 511) ? 511 : (q < -512) ? -512 : int'(q);
    if (!sel) return v < 0 ? 0 : v;
    k = (v >= 0) ? v / 8 : -((-v + 7) / 8);
    if (k > 31) k = 31;
    if (k < -32) k = -32;
    return sig_ref(k);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic beat(logic [N*DW-1:0] xv, logic [N*DW-1:0] wv, int b, bit clr, bit sel, string tag);
    longint s = 0;
    @(negedge clk);
    x_i = xv; w_i = wv; bias_i = DW'(b); clear_i = clr; act_sel_i = sel; enable_i = 1'b1;
    for (int i = 0; i < N; i++)
      s += longint'($signed(xv[i*DW +: DW])) * longint'($signed(wv[i*DW +: DW]));
    acc_m = clr ? longint'(b) * 64 + s : acc_m + s;
    last_exp = model_out(acc_m, sel);
    q_val.push_back(last_exp);
    q_cyc.push_back(cyc + LAT);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n, bit clr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enable_i = 1'b0; clear_i = clr;
    end
  endtask

  function automatic logic [N*DW-1:0] pk(int a, int b, int c, int d);
    return {DW'(d), DW'(c), DW'(b), DW'(a)};
  endfunction

  // monitor, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_ni) begin
      cyc++;
      if (valid_o) begin
        if (q_val.size() == 0) check("R2 unexpected valid", 1, 0);
        else begin
          check(q_tag[0], int'(y_o), q_val[0]);
          check("R2 latency", cyc, q_cyc[0]);
          void'(q_val.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 y in reset", int'(y_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", int'(valid_o), 0);
    check("R1 y after reset", int'(y_o), 0);

    beat(pk(64, 32, -16, 8), pk(32, 64, 64, -64), 10, 1, 0, "R3 clear with bias");
    beat(pk(16, 0, 0, 0), pk(64, 0, 0, 0), 0, 0, 0, "R4 accumulate");
    beat(pk(1, 0, 0, 0), pk(32, 0, 0, 0), 0, 1, 0, "R5 half rounds up");
    beat(pk(1, 0, 0, 0), pk(31, 0, 0, 0), 0, 1, 0, "R5 below half");
    beat(pk(3, 0, 0, 0), pk(32, 0, 0, 0), -1, 1, 0, "R5 bias alignment");
    beat(pk(511, 511, 511, 511), pk(511, 511, 511, 511), 0, 1, 0, "R6 saturate high");
    beat(pk(-512, 300, 0, 0), pk(511, 100, 0, 0), 0, 1, 0, "R7 relu negative");
    beat(pk(0, 0, 0, 0), pk(0, 0, 0, 0), 0, 1, 1, "R8 sigmoid centre");
    beat(pk(511, 511, 0, 0), pk(511, 511, 0, 0), 0, 1, 1, "R8 sigmoid clamp high");
    beat(pk(-512, -512, 0, 0), pk(511, 511, 0, 0), 0, 1, 1, "R8 sigmoid clamp low");
    beat(pk(64, 0, 0, 0), pk(80, 0, 0, 0), 0, 1, 1, "R8 sigmoid mid");
    beat(pk(-64, 0, 0, 0), pk(80, 0, 0, 0), 0, 1, 1, "R8 sigmoid mid negative");
    beat(pk(100, 20, 0, 0), pk(50, 40, 0, 0), 5, 1, 0, "R9 relu beat");
    beat(pk(100, 20, 0, 0), pk(50, 40, 0, 0), 5, 0, 1, "R9 sigmoid next beat");
    beat(pk(-30, 0, 0, 0), pk(70, 0, 0, 0), 2, 1, 0, "R9 clear next beat");
    idle(10, 1);
    check("R10 y held while idle", int'(y_o), last_exp);
    check("R10 no valid while idle", int'(valid_o), 0);
    beat(pk(40, 0, 0, 0), pk(64, 0, 0, 0), 0, 0, 0, "R3 clear ignored without enable");
    idle(8, 0);

    for (int n = 0; n < 240; n++) begin
      logic [N*DW-1:0] xv, wv;
      for (int i = 0; i < N; i++) begin
        xv[i*DW +: DW] = DW'($urandom_range(0, 1023));
        wv[i*DW +: DW] = DW'($urandom_range(0, 1023));
      end
      beat(xv, wv, int'($signed(DW'($urandom_range(0, 1023)))), (n % 4 == 0) || ($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 1)), "R4 random stream");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)), 1'($urandom_range(0, 1)));
    end
    idle(12, 0);
    check("R2 all results delivered", q_val.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule